// File: doc/BRIEF.md
# Bit-Serial CRC Encoder and Checker

This block computes and verifies a cyclic redundancy check one bit per accepted cycle. A single shift register, with taps chosen by a polynomial parameter, serves both directions. Each incoming bit is combined with the register's top bit before the taps are applied. As a result, the checksum of a k-bit message is complete after exactly k accepted bits, and no run of zero bits has to be shifted in afterwards.

A mode pin selects the register's behaviour. When it is high, the register divides the incoming stream by the generator, and the serial output copies the input bit so the message flows through. When it is low, the taps are switched off and the register becomes a plain left shifter that presents its top bit on the serial output. To transmit, hold the mode high for the message and then low for CRC_W accepted cycles. To receive, hold the mode high for the message and its appended checksum, then read the zero flag.

The bit interface is a valid strobe without a ready signal. The block takes a bit on every cycle in which the strobe is high and never applies back-pressure. Cycles with the strobe low leave the register untouched. A synchronous clear starts a new frame.

Top module: `crc_serial_unit`

## Requirements
- R1: Message bits are presented most significant first. After exactly k accepted bits in calculate mode, the register holds the remainder of message·x^CRC_W divided by the generator. For x^3+x^2+1 and message 1011011 this remainder is 001. For x^4+x^3+1 and message 110011 it is 1001.
- R2: With `mode_calc`=1, an accepted bit updates the register as follows: feedback = `bit_in` XOR the register top bit; the register shifts left; the feedback is XORed into every bit whose coefficient in `POLY` is 1. In this mode `bit_out` equals `bit_in`.
- R3: With `mode_calc`=0, `bit_out` equals the register top bit. An accepted cycle shifts the register left with a 0 fill and applies no taps. CRC_W such cycles therefore emit the checksum most significant bit first and leave the register at zero.
- R4: Feeding a message followed by its correct checksum, all in calculate mode, leaves the register at zero. For example, block 1100111001 under x^4+x^3+1 leaves zero.
- R5: `crc_zero` is combinational and is 1 exactly when the register is all zeros.
- R6: A cycle with `bit_valid`=0 leaves the register unchanged, whatever the values of `bit_in` and `mode_calc`.
- R7: `clr`=1 zeroes the register on the next edge and takes priority over `bit_valid`.
- R8: While `rst_n` is low, the register is held at zero.
- R9: `CRC_W` and `POLY` select the generator. `POLY` holds the coefficients below the leading term, with bit i being the coefficient of x^i. The 16-bit generators 16'h8005 (x^16+x^15+x^2+1) and 16'h1021 (x^16+x^12+x^5+1) both produce the remainder that long division gives.
- R10: A frame with one message bit inverted leaves a nonzero register, so `crc_zero` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous frame clear |
| bit_valid | input | 1 | Bit accepted on this edge |
| mode_calc | input | 1 | 1: calculate/check, 0: shift checksum out |
| bit_in | input | 1 | Serial data in, MSB first |
| bit_out | output | 1 | Serial data out |
| crc_zero | output | 1 | Register is all zeros |

## Verification
On every cycle the checker checks the following: the register holds when no bit is accepted, it clears, the shift-out path shifts without taps, a calculate step with zero feedback is a pure shift, the serial output is selected correctly, and the zero flag matches the register. Only the bench scenarios can show that whole frames yield the correct remainder. They are compared against an independent long division for small and 16-bit generators. The scenarios also show that a received frame with its checksum drains to zero and that a single flipped bit is caught.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;
  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_CALC  = 1'b1
  } crc_mode_e;
endpackage

// File: rtl/crc_next_state.sv
module crc_next_state #(
  parameter int          CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8005
) (
  input  logic [CRC_W-1:0] cur,
  input  logic             din,
  input  logic             calc,
  output logic [CRC_W-1:0] nxt
);
  logic fb;
  logic tap_en;

  assign fb     = din ^ cur[CRC_W-1];
  assign tap_en = calc & fb;

  // Bit 0 takes only the constant term; higher bits take the shifted neighbour.
  assign nxt[0] = POLY[0] & tap_en;

  for (genvar i = 1; i < CRC_W; i++) begin : g_bit
    if (POLY[i]) begin : g_tap
      assign nxt[i] = cur[i-1] ^ tap_en;
    end else begin : g_plain
      assign nxt[i] = cur[i-1];
    end
  end
endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg #(
  parameter int CRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CRC_W-1:0] d,
  output logic [CRC_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (clr) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/crc_zero_detect.sv
module crc_zero_detect #(
  parameter int CRC_W = 16
) (
  input  logic [CRC_W-1:0] val,
  output logic             is_zero
);
  assign is_zero = ~|val;
endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit
  import crc_serial_pkg::*;
#(
  parameter int               CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY  = 16'h8005
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_valid,
  input  logic mode_calc,
  input  logic bit_in,
  output logic bit_out,
  output logic crc_zero
);
  localparam int TOP = CRC_W - 1;

  crc_mode_e        mode;
  logic [CRC_W-1:0] state_q;
  logic [CRC_W-1:0] state_d;

  assign mode = crc_mode_e'(mode_calc);

  crc_next_state #(.CRC_W(CRC_W), .POLY(POLY)) u_next (
    .cur  (state_q),
    .din  (bit_in),
    .calc (mode == MODE_CALC),
    .nxt  (state_d)
  );

  crc_state_reg #(.CRC_W(CRC_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .en    (bit_valid),
    .d     (state_d),
    .q     (state_q)
  );

  crc_zero_detect #(.CRC_W(CRC_W)) u_zero (
    .val     (state_q),
    .is_zero (crc_zero)
  );

  assign bit_out = (mode == MODE_CALC) ? bit_in : state_q[TOP];
endmodule

// File: rtl/crc_serial_unit_chk.sv
module crc_serial_unit_chk #(
  parameter int CRC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             bit_valid,
  input logic             mode_calc,
  input logic             bit_in,
  input logic             bit_out,
  input logic             crc_zero,
  input logic [CRC_W-1:0] state
);
  // R8: reset holds the register at zero
  a_r8_reset_zero: assert property (@(posedge clk) !rst_n |=> state == '0);

  // R6: no accepted bit, no change
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !bit_valid) |=> $stable(state));

  // R7: clear wins over valid
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> state == '0);

  // R3: shift-out path is a plain shift with zero fill
  a_r3_plain_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bit_valid && !mode_calc) |=> state == {$past(state[CRC_W-2:0]), 1'b0});

  // R3: output shows the register top bit in shift-out mode
  a_r3_out_top: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_calc |-> bit_out == state[CRC_W-1]);

  // R2: zero feedback applies no taps
  a_r2_zero_fb: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bit_valid && mode_calc && (bit_in == state[CRC_W-1]))
      |=> state == {$past(state[CRC_W-2:0]), 1'b0});

  // R2: message passes through in calculate mode
  a_r2_echo: assert property (@(posedge clk) disable iff (!rst_n)
    mode_calc |-> bit_out == bit_in);

  // R5: flag tracks the register
  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    crc_zero == (state == '0));
endmodule

bind crc_serial_unit crc_serial_unit_chk #(.CRC_W(CRC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .bit_valid (bit_valid),
  .mode_calc (mode_calc),
  .bit_in    (bit_in),
  .bit_out   (bit_out),
  .crc_zero  (crc_zero),
  .state     (state_q)
);

// File: tb/crc_serial_unit_tb_top.sv
`timescale 1ns/1ps
module crc_serial_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic valid = 1'b0;
  logic mode = 1'b0;
  logic din = 1'b0;
  logic [3:0] bo;
  logic [3:0] zr;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // index 0: x^3+x^2+1, 1: x^4+x^3+1, 2: 16'h8005, 3: 16'h1021
  crc_serial_unit #(.CRC_W(3), .POLY(3'b101)) d3_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_valid(valid), .mode_calc(mode),
    .bit_in(din), .bit_out(bo[0]), .crc_zero(zr[0]));
  crc_serial_unit #(.CRC_W(4), .POLY(4'b1001)) d4_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_valid(valid), .mode_calc(mode),
    .bit_in(din), .bit_out(bo[1]), .crc_zero(zr[1]));
  crc_serial_unit #(.CRC_W(16), .POLY(16'h8005)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_valid(valid), .mode_calc(mode),
    .bit_in(din), .bit_out(bo[2]), .crc_zero(zr[2]));
  crc_serial_unit #(.CRC_W(16), .POLY(16'h1021)) dcc_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_valid(valid), .mode_calc(mode),
    .bit_in(din), .bit_out(bo[3]), .crc_zero(zr[3]));

  localparam int NV = 5;
  localparam logic [15:0] V_MSG [NV] = '{16'hFFFF, 16'h0001, 16'h00A5, 16'h0001, 16'h1234};
  localparam int          V_LEN [NV] = '{16, 16, 8, 1, 13};

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at the falling edge, settle, leave outputs ready to sample
  task automatic drive(input logic c, input logic v, input logic m, input logic b);
    @(negedge clk);
    clr = c; valid = v; mode = m; din = b;
    #1;
  endtask

  // long-division reference: append w zeros, reduce by the full generator
  function automatic logic [15:0] ref_crc(input int w, input logic [15:0] poly,
                                          input logic [15:0] msg, input int k);
    logic [16:0] gen;
    logic [16:0] rem;
    gen = 17'(1) << w;
    gen = gen | {1'b0, poly};
    rem = '0;
    for (int i = k - 1; i >= -w; i--) begin
      rem = {rem[15:0], (i >= 0) ? msg[i] : 1'b0};
      if (rem[w]) rem = rem ^ gen;
    end
    return rem[15:0];
  endfunction

  task automatic run_frame(input int sel, input int w, input int k,
                           input logic [15:0] msg, input logic [15:0] exp);
    logic [15:0] got;
    bit echo_ok;
    got = '0;
    echo_ok = 1'b1;
    drive(1, 0, 1, 0);
    for (int i = k - 1; i >= 0; i--) begin
      drive(0, 1, 1, msg[i]);
      if (bo[sel] !== msg[i]) echo_ok = 1'b0;
    end
    check(echo_ok, "R2 message echo", {15'd0, bo[sel]}, {15'd0, msg[0]});
    for (int i = w - 1; i >= 0; i--) begin
      drive(0, 1, 0, 1);
      got[i] = bo[sel];
    end
    drive(0, 0, 0, 0);
    check(got === exp, "R1/R9 remainder after k bits", got, exp);
    check(zr[sel] === 1'b1, "R3 register drained after shift-out", {15'd0, zr[sel]}, 16'd1);
    // receive path
    drive(1, 0, 1, 0);
    for (int i = k - 1; i >= 0; i--) drive(0, 1, 1, msg[i]);
    for (int i = w - 1; i >= 0; i--) drive(0, 1, 1, exp[i]);
    drive(0, 0, 1, 0);
    check(zr[sel] === 1'b1, "R4 good frame leaves zero", {15'd0, zr[sel]}, 16'd1);
    // corrupted: lowest message bit flipped
    drive(1, 0, 1, 0);
    for (int i = k - 1; i >= 0; i--) drive(0, 1, 1, (i == 0) ? ~msg[i] : msg[i]);
    for (int i = w - 1; i >= 0; i--) drive(0, 1, 1, exp[i]);
    drive(0, 0, 1, 0);
    check(zr[sel] === 1'b0, "R10 flipped bit detected", {15'd0, zr[sel]}, 16'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    logic [15:0] e;
    // R8: reset state
    repeat (3) @(posedge clk);
    #1;
    check(zr === 4'hF, "R8 zero during reset", {12'd0, zr}, 16'h000F);
    drive(0, 0, 1, 0);
    rst_n = 1'b1;
    drive(0, 0, 1, 0);
    check(zr === 4'hF, "R8 zero after reset", {12'd0, zr}, 16'h000F);

    // R1: worked examples
    run_frame(0, 3, 7, 16'b1011011, 16'b001);
    run_frame(1, 4, 6, 16'b110011, 16'b1001);
    check(ref_crc(4, 16'h9, 16'b110011, 6) === 16'h9, "R1 reference model sanity",
          ref_crc(4, 16'h9, 16'b110011, 6), 16'h9);

    // R9: table walk over both 16-bit generators
    for (int v = 0; v < NV; v++) begin
      e = ref_crc(16, 16'h8005, V_MSG[v], V_LEN[v]);
      run_frame(2, 16, V_LEN[v], V_MSG[v], e);
      e = ref_crc(16, 16'h1021, V_MSG[v], V_LEN[v]);
      run_frame(3, 16, V_LEN[v], V_MSG[v], e);
    end

    // R6: idle cycles with noise on din and mode change nothing
    drive(1, 0, 1, 0);
    drive(0, 1, 1, 1); drive(0, 1, 1, 0); drive(0, 1, 1, 1); drive(0, 1, 1, 1);
    for (int i = 0; i < 6; i++) drive(0, 0, i[0], i[1]);
    drive(0, 1, 1, 0); drive(0, 1, 1, 1); drive(0, 1, 1, 1);
    got = '0;
    for (int i = 2; i >= 0; i--) begin
      drive(0, 1, 0, 0);
      got[i] = bo[0];
    end
    check(got === 16'b001, "R6 idle cycles ignored", got, 16'b001);

    // R5 and R7: nonzero flag, then clear wins over valid
    drive(1, 0, 1, 0);
    drive(0, 1, 1, 1);
    drive(0, 0, 1, 0);
    check(zr[1] === 1'b0, "R5 flag low on nonzero register", {15'd0, zr[1]}, 16'd0);
    drive(1, 1, 1, 1);
    drive(0, 0, 1, 0);
    check(zr === 4'hF, "R7 clear overrides valid", {12'd0, zr}, 16'h000F);

    // R3: output shows top bit in shift mode (register 1001 after message 1)
    drive(0, 1, 1, 1);
    drive(0, 0, 0, 0);
    check(bo[1] === 1'b1, "R3 top bit on output", {15'd0, bo[1]}, 16'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule